// File: doc/BRIEF.md
# Infrared Pulse-Timing Code Receiver

This block turns a demodulated infrared receiver line into a code word of up to 48 bits. Every symbol on the line is a high pulse followed by a low space. The block counts the pulse width and the whole period (pulse plus space) in IR clock cycles, and checks both against programmable min/max windows. One window set is for an optional leader symbol. Four window sets are for data-symbol classes. Each decoded data bit is shifted into a 64-bit word.

A code ends when the line stays low for longer than a programmed free time. The code is reported only when its bit count falls inside a length window that is rounded to even values. The report sets a data-valid flag, which stays set until software clears it. The IR clock is normally 32768 Hz, and all timing fields count in cycles of that clock.

Software programs the block through a simple write port and reads it through a combinational read port.

Top module: `ird_decoder`

## Requirements

- R1: After reset, every register reads zero and `data_valid` is low.

- R2: With leader decoding enabled (control bit 1), the first symbol of a code must be a leader. A leader has a pulse width in [16·wmin, 16·wmax] and a period in [16·pmin, 16·pmax], all bounds inclusive. Any symbol that fails this check leaves the decoder waiting for a leader. The leader is not a data bit.

- R3: Data symbols are checked against four class windows at addresses 2 to 5. Classes 00/01/10/11 sit at addresses 2, 3, 4 and 5, and the lowest-numbered matching class wins.
  - The pulse width must lie in [wmin, wmax], with bounds inclusive.
  - The period must lie in [2·pmin, 2·pmax].
  - Every timing register has the layout pmax[31:24], pmin[23:16], wmax[15:8], wmin[7:0].
  - A class decodes as the bit value of its low index bit, so classes 00 and 10 give 0, and classes 01 and 11 give 1.

- R4: Control bit 3 selects the bit orientation.
  - With bit 3 = 0, the k-th received bit lands at word bit k.
  - With bit 3 = 1, bits shift in at bit 0, so the first bit ends at bit length−1.

- R5: Control bit 4 inverts every decoded data bit.

- R6: Control bit 2 inverts the IR input before any measurement.

- R7: The free-time register holds the minimum idle time in bits [12:0], in units of 8 cycles.
  - A space of exactly 8·ft cycles continues the code.
  - A space of 8·ft+1 cycles ends it.

- R8: The free-time register holds the minimum length in bits [20:16] and the maximum length in bits [29:24].
  - The minimum length rounds down to even.
  - The maximum length rounds up to even and is capped at 48.
  - A code whose bit count lies outside [min, max] is discarded.

- R9: A data symbol that matches no class aborts the code without a report.

- R10: An accepted code does three things. It sets status bit 0 (mirrored on `data_valid`). It writes the bit count into status bits [14:8]. It stores the word, readable as the low word (address 8) and the high word (address 9). While a code is being received, `data_valid` stays low.

- R11: Writing the status register (address 7) with bit 0 zero clears `data_valid`. Writing it with bit 0 set leaves the flag unchanged.

- R12: Control bit 0 enables decoding, and code-type field [9:8] must be 0 for decoding to run. Writing control zero stops decoding. Any write to control restarts reception from idle.

- R13: With leader decoding disabled, the first symbol is decoded as data.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | IR sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated IR line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| data_valid | output | 1 | A received code is waiting to be read |

## Verification

The hardest state to reach from the ports is the decoder after an abort. A code must first get past its leader, then meet a symbol that matches no window. The remaining symbols are then retried as leaders, and this must end silently. The bench reaches this state by inserting one symbol with a wrong period in the middle of a valid frame.

The end-of-code boundary needs the same kind of construction. Every frame carries a leader space of exactly the free time, which must continue the code. A separate frame stretches that space by one cycle, which must end the code.

Width-window edges are reached by sending whole frames at the minimum and maximum pulse widths. Length rounding is reached by writing odd length limits and sending codes one bit either side of them.

// File: rtl/ird_pkg.sv
package ird_pkg;

    localparam int DATA_W   = 64;
    localparam int LEN_W    = 7;
    localparam int MAX_CODE = 48;
    localparam int LDR_SH   = 4;
    localparam int PD_SH    = 1;

    typedef enum logic [3:0] {
        A_CTRL = 4'd0,
        A_LDR  = 4'd1,
        A_C00  = 4'd2,
        A_C01  = 4'd3,
        A_C10  = 4'd4,
        A_C11  = 4'd5,
        A_FREE = 4'd6,
        A_STAT = 4'd7,
        A_DLO  = 4'd8,
        A_DHI  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic [7:0] pd_max;
        logic [7:0] pd_min;
        logic [7:0] w_max;
        logic [7:0] w_min;
    } sym_win_t;

    typedef struct packed {
        logic [1:0] code_type;
        logic       bit_inv;
        logic       msb_first;
        logic       pol_inv;
        logic       ldr_en;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]  max_len;
        logic [4:0]  min_len;
        logic [12:0] ft_min;
    } free_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PULSE = 2'd1,
        S_SPACE = 2'd2
    } dec_state_e;

    function automatic logic [LEN_W-1:0] min_even(input logic [4:0] m);
        return {2'b00, m[4:1], 1'b0};
    endfunction

    function automatic logic [LEN_W-1:0] max_even(input logic [5:0] m);
        logic [LEN_W-1:0] r;
        r = ({1'b0, m} + LEN_W'(1)) & ~LEN_W'(1);
        if (r > LEN_W'(MAX_CODE)) r = LEN_W'(MAX_CODE);
        return r;
    endfunction

endpackage

// File: rtl/ird_input.sv
module ird_input (
    input  logic clk,
    input  logic rst,
    input  logic ir_in,
    input  logic pol_inv,
    output logic line,
    output logic rise
);
    logic line_q, line_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            line_p <= 1'b0;
        end else begin
            line_q <= ir_in ^ pol_inv;
            line_p <= line_q;
        end
    end

    assign line = line_q;
    assign rise = line_q & ~line_p;
endmodule

// File: rtl/ird_classify.sv
module ird_classify
    import ird_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]   wid,
    input  logic [CNT_W-1:0]   per,
    input  sym_win_t           ldr,
    input  sym_win_t [3:0]     cls,
    output logic               ldr_hit,
    output logic               bit_hit,
    output logic               bit_val
);
    logic [CNT_W-1:0] l_wlo, l_whi, l_plo, l_phi;
    logic [3:0]       hit;

    assign l_wlo = CNT_W'(ldr.w_min) << LDR_SH;
    assign l_whi = CNT_W'(ldr.w_max) << LDR_SH;
    assign l_plo = CNT_W'(ldr.pd_min) << LDR_SH;
    assign l_phi = CNT_W'(ldr.pd_max) << LDR_SH;

    assign ldr_hit = (wid >= l_wlo) && (wid <= l_whi) &&
                     (per >= l_plo) && (per <= l_phi);

    for (genvar k = 0; k < 4; k++) begin : g_cls
        logic [CNT_W-1:0] plo, phi;
        assign plo = CNT_W'(cls[k].pd_min) << PD_SH;
        assign phi = CNT_W'(cls[k].pd_max) << PD_SH;
        assign hit[k] = (wid >= CNT_W'(cls[k].w_min)) &&
                        (wid <= CNT_W'(cls[k].w_max)) &&
                        (per >= plo) && (per <= phi);
    end

    always_comb begin
        bit_val = 1'b0;
        for (int k = 3; k >= 0; k--) begin
            if (hit[k]) bit_val = k[0];
        end
    end

    assign bit_hit = |hit;
endmodule

// File: rtl/ird_engine.sv
module ird_engine
    import ird_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              enable,
    input  logic              ldr_en,
    input  logic              msb_first,
    input  logic              bit_inv,
    input  logic [CNT_W-1:0]  ft_lim,
    input  logic [LEN_W-1:0]  min_len,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              line,
    input  logic              rise,
    input  logic              ldr_hit,
    input  logic              bit_hit,
    input  logic              bit_val,
    output logic [CNT_W-1:0]  wid,
    output logic [CNT_W-1:0]  per,
    output logic              done,
    output logic [LEN_W-1:0]  done_len,
    output logic [DATA_W-1:0] done_data
);
    localparam int IDX_W = $clog2(DATA_W);

    dec_state_e        st;
    logic [CNT_W-1:0]  cnt, sp;
    logic [LEN_W-1:0]  nbits;
    logic [DATA_W-1:0] shreg;
    logic              have, ldr_ok;
    logic              need_ldr, b, len_ok;

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + CNT_W'(1);
    endfunction

    assign per      = cnt;
    assign need_ldr = ldr_en & ~ldr_ok;
    assign b        = bit_val ^ bit_inv;
    assign len_ok   = have && (nbits >= min_len) && (nbits <= max_len);

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            st        <= S_IDLE;
            cnt       <= '0;
            sp        <= '0;
            wid       <= '0;
            nbits     <= '0;
            shreg     <= '0;
            have      <= 1'b0;
            ldr_ok    <= 1'b0;
            done      <= 1'b0;
            if (rst) begin
                done_len  <= '0;
                done_data <= '0;
            end
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (rise) begin
                        cnt <= CNT_W'(1);
                        st  <= S_PULSE;
                    end
                end
                S_PULSE: begin
                    if (line) begin
                        cnt <= bump(cnt);
                    end else begin
                        wid <= cnt;
                        cnt <= bump(cnt);
                        sp  <= CNT_W'(1);
                        st  <= S_SPACE;
                    end
                end
                S_SPACE: begin
                    if (line) begin
                        if (need_ldr && ldr_hit) begin
                            ldr_ok <= 1'b1;
                            have   <= 1'b1;
                        end else if (!need_ldr && bit_hit &&
                                     nbits < LEN_W'(DATA_W-1)) begin
                            if (msb_first) shreg <= {shreg[DATA_W-2:0], b};
                            else           shreg[nbits[IDX_W-1:0]] <= b;
                            nbits <= nbits + LEN_W'(1);
                            have  <= 1'b1;
                        end else begin
                            nbits  <= '0;
                            shreg  <= '0;
                            have   <= 1'b0;
                            ldr_ok <= 1'b0;
                        end
                        cnt <= CNT_W'(1);
                        st  <= S_PULSE;
                    end else if (sp >= ft_lim) begin
                        if (len_ok) begin
                            done      <= 1'b1;
                            done_len  <= nbits;
                            done_data <= shreg;
                        end
                        nbits  <= '0;
                        shreg  <= '0;
                        have   <= 1'b0;
                        ldr_ok <= 1'b0;
                        st     <= S_IDLE;
                    end else begin
                        cnt <= bump(cnt);
                        sp  <= bump(sp);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ird_decoder.sv
module ird_decoder
    import ird_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ir_in,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        data_valid
);
    ctrl_t             ctrl_q;
    sym_win_t          ldr_win;
    sym_win_t [3:0]    cls_win;
    free_t             free_q;
    logic              stat_valid;
    logic [LEN_W-1:0]  stat_len;
    logic [DATA_W-1:0] data_q;

    logic              line, rise, ldr_hit, bit_hit, bit_val;
    logic [CNT_W-1:0]  wid, per, ft_lim;
    logic [LEN_W-1:0]  min_e, max_e, eng_len;
    logic [DATA_W-1:0] eng_data;
    logic              eng_done, eng_en, restart;

    assign restart = wr_en && (wr_addr == A_CTRL);
    assign eng_en  = ctrl_q.enable && (ctrl_q.code_type == 2'd0);
    assign ft_lim  = CNT_W'({free_q.ft_min, 3'b000});
    assign min_e   = min_even(free_q.min_len);
    assign max_e   = max_even(free_q.max_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            ldr_win    <= '0;
            free_q     <= '0;
            stat_valid <= 1'b0;
            stat_len   <= '0;
            data_q     <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL: ctrl_q <= '{code_type: wr_data[9:8], bit_inv: wr_data[4],
                                        msb_first: wr_data[3], pol_inv: wr_data[2],
                                        ldr_en: wr_data[1], enable: wr_data[0]};
                    A_LDR:  ldr_win <= sym_win_t'(wr_data);
                    A_FREE: free_q <= '{max_len: wr_data[29:24], min_len: wr_data[20:16],
                                        ft_min: wr_data[12:0]};
                    default: ;
                endcase
            end
            if (eng_done) begin
                stat_valid <= 1'b1;
                stat_len   <= eng_len;
                data_q     <= eng_data;
            end else if (wr_en && wr_addr == A_STAT && !wr_data[0]) begin
                stat_valid <= 1'b0;
            end
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) cls_win[k] <= '0;
            else if (wr_en && wr_addr == 4'(A_C00) + 4'(k)) cls_win[k] <= sym_win_t'(wr_data);
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: rd_data = {22'd0, ctrl_q.code_type, 3'd0, ctrl_q.bit_inv,
                               ctrl_q.msb_first, ctrl_q.pol_inv, ctrl_q.ldr_en, ctrl_q.enable};
            A_LDR:  rd_data = ldr_win;
            A_C00:  rd_data = cls_win[0];
            A_C01:  rd_data = cls_win[1];
            A_C10:  rd_data = cls_win[2];
            A_C11:  rd_data = cls_win[3];
            A_FREE: rd_data = {2'd0, free_q.max_len, 3'd0, free_q.min_len, 3'd0, free_q.ft_min};
            A_STAT: rd_data = {17'd0, stat_len, 7'd0, stat_valid};
            A_DLO:  rd_data = data_q[31:0];
            A_DHI:  rd_data = data_q[63:32];
            default: rd_data = '0;
        endcase
    end

    assign data_valid = stat_valid;

    ird_input u_in (
        .clk(clk), .rst(rst), .ir_in(ir_in), .pol_inv(ctrl_q.pol_inv),
        .line(line), .rise(rise)
    );

    ird_classify #(.CNT_W(CNT_W)) u_cls (
        .wid(wid), .per(per), .ldr(ldr_win), .cls(cls_win),
        .ldr_hit(ldr_hit), .bit_hit(bit_hit), .bit_val(bit_val)
    );

    ird_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(rst), .restart(restart), .enable(eng_en),
        .ldr_en(ctrl_q.ldr_en), .msb_first(ctrl_q.msb_first), .bit_inv(ctrl_q.bit_inv),
        .ft_lim(ft_lim), .min_len(min_e), .max_len(max_e),
        .line(line), .rise(rise), .ldr_hit(ldr_hit), .bit_hit(bit_hit), .bit_val(bit_val),
        .wid(wid), .per(per), .done(eng_done), .done_len(eng_len), .done_data(eng_data)
    );
endmodule

// File: rtl/ird_checker.sv
module ird_checker (
    input logic        clk,
    input logic        rst,
    input logic        data_valid,
    input logic        eng_done,
    input logic        eng_en,
    input logic [6:0]  eng_len,
    input logic [6:0]  min_e,
    input logic [6:0]  max_e,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [31:0] wr_data
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == 4'd7) && !wr_data[0];

    // R10: the flag only rises after the engine has reported a code
    a_r10_valid_from_report: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $past(eng_done));

    // R8: reported lengths lie inside the rounded length window
    a_r8_len_window: assert property (@(posedge clk) disable iff (rst)
        eng_done |-> (eng_len >= min_e) && (eng_len <= max_e));

    // R8: no report is longer than 48 bits
    a_r8_len_cap: assert property (@(posedge clk) disable iff (rst)
        eng_done |-> eng_len <= 7'd48);

    // R11: a clearing status write drops the flag
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !eng_done) |=> !data_valid);

    // R11: the flag holds until cleared
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !clr_wr) |=> data_valid);

    // R12: a stopped decoder produces no report
    a_r12_stopped: assert property (@(posedge clk) disable iff (rst)
        !eng_en |=> !eng_done);
endmodule

bind ird_decoder ird_checker u_chk (
    .clk(clk), .rst(rst), .data_valid(data_valid), .eng_done(eng_done),
    .eng_en(eng_en), .eng_len(eng_len), .min_e(min_e), .max_e(max_e),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_ird_decoder.sv
module sim_ird_decoder;
    localparam int CLK_P = 10;
    localparam int FT    = 4;
    localparam int FREE_DEF = (63 << 24) | (2 << 16) | FT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lvl = 1'b0;
    logic        tb_inv = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        data_valid;
    logic        ir_in;

    int nchk = 0;
    int nerr = 0;
    bit ended = 1'b0;

    assign ir_in = lvl ^ tb_inv;
    always #(CLK_P/2) clk = ~clk;

    ird_decoder u0 (
        .clk(clk), .rst(rst), .ir_in(ir_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .data_valid(data_valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // one symbol: h cycles high then l cycles low; no report may appear mid-code (R10)
    task automatic sym(input int h, input int l);
        for (int i = 0; i < h + l; i++) begin
            lvl = (i < h);
            @(negedge clk);
            chk("R10 valid low mid-code", 64'(data_valid), 64'd0);
        end
    endtask

    task automatic idle(input int n);
        lvl = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input bit ldr, input int n, input logic [63:0] bits,
                         input int hw, input bit alt, input int ldr_sp);
        if (ldr) sym(64, ldr_sp);
        for (int i = 0; i < n; i++) begin
            if (!bits[i] && alt) sym(9, 11);
            else sym(hw, (bits[i] ? 16 : 8) - hw);
        end
        sym(4, 0);
        idle(8 * FT + 13);
    endtask

    function automatic logic [63:0] expw(input int n, input logic [63:0] b,
                                         input bit msb, input bit inv);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) begin
            if (msb) r = {r[62:0], b[i] ^ inv};
            else     r[i] = b[i] ^ inv;
        end
        return r;
    endfunction

    task automatic expect_code(input string tag, input bit v, input int len, input logic [63:0] d);
        logic [31:0] s, lo, hi;
        rd(4'd7, s);
        chk({tag, " valid"}, 64'(s[0]), 64'(v));
        chk({tag, " port"}, 64'(data_valid), 64'(v));
        if (v) begin
            rd(4'd8, lo);
            rd(4'd9, hi);
            chk({tag, " length"}, 64'(s[14:8]), 64'(len));
            chk({tag, " data"}, {hi, lo}, d);
        end
        wr(4'd7, 32'd0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!ended) begin
            nerr++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] b48;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk("R1 reset register", 64'(v), 64'd0);
        end
        chk("R1 reset valid", 64'(data_valid), 64'd0);

        wr(4'd1, {8'd7, 8'd5, 8'd5, 8'd3});
        wr(4'd2, {8'd5, 8'd3, 8'd5, 8'd3});
        wr(4'd3, {8'd9, 8'd7, 8'd5, 8'd3});
        wr(4'd4, {8'd11, 8'd9, 8'd10, 8'd8});
        wr(4'd5, {8'd0, 8'd1, 8'd0, 8'd1});
        wr(4'd6, FREE_DEF);
        wr(4'd0, 32'h3);
        idle(4);

        // R2 R3 R7 R10: leader + 8 bits, LSB first
        frame(1, 8, 64'hA5, 4, 0, 32);
        expect_code("R2 R3 basic", 1, 8, 64'hA5);

        // R3 inclusive width bounds
        frame(1, 8, 64'h3C, 3, 0, 32);
        expect_code("R3 min width", 1, 8, 64'h3C);
        frame(1, 8, 64'hC3, 5, 0, 32);
        expect_code("R3 max width", 1, 8, 64'hC3);

        // R3 class 10 decodes as 0
        frame(1, 8, 64'h0F, 4, 1, 32);
        expect_code("R3 class10", 1, 8, 64'h0F);

        // R4 MSB first
        wr(4'd0, 32'hB);
        frame(1, 8, 64'hA6, 4, 0, 32);
        expect_code("R4 msb first", 1, 8, expw(8, 64'hA6, 1, 0));

        // R5 data inversion
        wr(4'd0, 32'h13);
        frame(1, 8, 64'hA6, 4, 0, 32);
        expect_code("R5 invert", 1, 8, expw(8, 64'hA6, 0, 1));

        // R6 input polarity
        tb_inv = 1'b1;
        wr(4'd0, 32'h7);
        idle(60);
        frame(1, 8, 64'h5A, 4, 0, 32);
        expect_code("R6 polarity", 1, 8, 64'h5A);
        tb_inv = 1'b0;
        wr(4'd0, 32'h3);
        idle(60);
        wr(4'd7, 32'd0);

        // R9 bad symbol aborts
        lvl = 1'b0;
        sym(64, 32);
        for (int i = 0; i < 3; i++) sym(4, 4);
        sym(4, 30);
        for (int i = 0; i < 3; i++) sym(4, 12);
        sym(4, 0);
        idle(8 * FT + 13);
        expect_code("R9 abort", 0, 0, 0);

        // R8 48-bit code accepted, 49 rejected
        b48 = 64'h0000_9C3A_5E71_F00D;
        frame(1, 48, b48, 4, 0, 32);
        expect_code("R8 48 bits", 1, 48, b48);
        frame(1, 49, b48 | 64'h1_0000_0000_0000, 4, 0, 32);
        expect_code("R8 49 bits", 0, 0, 0);

        // R8 odd limits: min 7->6, max 7->8
        wr(4'd6, (7 << 24) | (7 << 16) | FT);
        frame(1, 5, 64'h15, 4, 0, 32);
        expect_code("R8 below min", 0, 0, 0);
        frame(1, 6, 64'h2D, 4, 0, 32);
        expect_code("R8 at min", 1, 6, 64'h2D);
        frame(1, 8, 64'h81, 4, 0, 32);
        expect_code("R8 at max", 1, 8, 64'h81);
        frame(1, 9, 64'h181, 4, 0, 32);
        expect_code("R8 above max", 0, 0, 0);
        wr(4'd6, FREE_DEF);

        // R7 leader space of free time + 1 ends the code
        frame(1, 8, 64'hA5, 4, 0, 33);
        expect_code("R7 timeout after leader", 0, 0, 0);

        // R11 status clear semantics
        frame(1, 8, 64'h77, 4, 0, 32);
        wr(4'd7, 32'd1);
        chk("R11 write one keeps", 64'(data_valid), 64'd1);
        wr(4'd7, 32'd0);
        chk("R11 write zero clears", 64'(data_valid), 64'd0);

        // R12 control zero stops
        wr(4'd0, 32'h0);
        frame(1, 8, 64'hA5, 4, 0, 32);
        expect_code("R12 stopped", 0, 0, 0);
        wr(4'd0, 32'h103);
        frame(1, 8, 64'hA5, 4, 0, 32);
        expect_code("R12 other code type", 0, 0, 0);

        // R13 no leader needed
        wr(4'd0, 32'h1);
        frame(0, 8, 64'h96, 4, 0, 32);
        expect_code("R13 leader off", 1, 8, 64'h96);

        // R2 missing leader
        wr(4'd0, 32'h3);
        frame(0, 8, 64'h96, 4, 0, 32);
        expect_code("R2 missing leader", 0, 0, 0);

        report();
        $finish;
    end
endmodule